// File: doc/BRIEF.md
# RV64I Integer ALU with Word Operations

This block is the combinational integer execution unit of a 64-bit RISC-V core. It takes the instruction word, the program counter of that instruction and the two source-register values, and it returns the value to be written to the destination register. It covers the register-register and register-immediate arithmetic, logic, shift and compare instructions. It also covers their 32-bit word forms and the two upper-immediate instructions.

Decoding uses the 7-bit opcode in bits [6:0], funct3 in bits [14:12] and funct7 in bits [31:25]. Instruction bit 30 picks subtract over add and arithmetic over logical right shift. The word forms work on the low 32 bits and sign-extend bit 31 of the result into the upper half. The register-file, load/store and branch logic sit around the block, and the block holds no state.

Top module: `rv64_int_alu`

## Requirements
- R1: With opcode 0x33 and funct3 000, the result is rs1+rs2, or rs1-rs2 when bit 30 is set. Both wrap modulo 2^64 and no overflow is flagged.
- R2: With opcode 0x13, the operand is the 12-bit immediate in bits [31:20], sign-extended to 64 bits, and the rs2 value has no effect. funct3 000 gives rs1+imm.
- R3: funct3 100, 110 and 111 give xor, or and and, both on rs2 (opcode 0x33) and on the sign-extended immediate (opcode 0x13).
- R4: The 64-bit shifts (funct3 001 for left, 101 for right) use only the low 6 bits of the amount. In the immediate form, bit 25 is amount bit 5.
- R5: Bit 30 selects the arithmetic right shift in both the register and the immediate encodings. In an immediate add, bit 30 is only immediate bit 10.
- R6: funct3 010 compares signed and funct3 011 compares unsigned, against rs2 or against the sign-extended immediate. The result is 1 when rs1 is less, otherwise 0.
- R7: The word add, subtract and add-immediate (opcodes 0x3B and 0x1B, funct3 000) compute on the low 32 bits and sign-extend bit 31. The upper input bits have no effect.
- R8: The word shifts (funct3 001 and 101 under opcodes 0x3B and 0x1B) use a 5-bit amount and shift only rs1 bits [31:0]. The right shift fills with zeros, or with copies of bit 31 when bit 30 is set, and the result is sign-extended from bit 31.
- R9: Opcode 0x37 gives bits [31:12] placed at result bits [31:12], zeros below and bit 31 copied above.
- R10: Opcode 0x17 gives the PC plus that same upper-immediate value, modulo 2^64.
- R11: Any other opcode, and a word opcode with a funct3 other than 000, 001 or 101, gives a result of zero.
- R12: The register index fields (bits [11:7], [19:15] and [24:20] in the register form) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word being executed |
| pc_i | input | XLEN | Address of that instruction |
| rs1_val_i | input | XLEN | First source register value |
| rs2_val_i | input | XLEN | Second source register value |
| rd_val_o | output | XLEN | Value for the destination register |

## Verification
The bench builds the block with XLEN at its default of 64, so the word width of 32 lies strictly inside the datapath. At that width the 6-bit shift-amount boundary, amount bit 5 carried in instruction bit 25, and the sign extension from bit 31 can all be reached. Register-index fields are set to nonzero values throughout, and junk is placed on the rs2 value in immediate forms, so any leak of those bits into the result shows up.

// File: rtl/rv64_alu_pkg.sv
package rv64_alu_pkg;

  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_REG_W  = 7'h3B;
  localparam logic [6:0] OPC_IMM_W  = 7'h1B;
  localparam logic [6:0] OPC_UPPER  = 7'h37;
  localparam logic [6:0] OPC_PCREL  = 7'h17;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SHL,
    ALU_LT_S,
    ALU_LT_U,
    ALU_XOR,
    ALU_SHR_L,
    ALU_SHR_A,
    ALU_OR,
    ALU_AND,
    ALU_PASS_B
  } alu_op_e;

endpackage

// File: rtl/rv64_alu_decode.sv
module rv64_alu_decode
  import rv64_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output alu_op_e         op_o,
  output logic            word_o,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o
);

  logic [6:0]      opcode;
  logic [2:0]      fn3;
  logic            alt;
  logic [XLEN-1:0] imm_short;
  logic [XLEN-1:0] imm_upper;
  logic            unused_rd;

  assign opcode    = insn_i[6:0];
  assign fn3       = insn_i[14:12];
  assign alt       = insn_i[30];
  assign imm_short = {{(XLEN-12){insn_i[31]}}, insn_i[31:20]};
  assign imm_upper = {{(XLEN-32){insn_i[31]}}, insn_i[31:12], 12'b0};
  assign unused_rd = ^insn_i[11:7];

  function automatic alu_op_e map_fn3(input logic [2:0] f, input logic sub_ok,
                                      input logic alt_bit);
    alu_op_e r;
    case (f)
      3'b000:  r = (sub_ok && alt_bit) ? ALU_SUB : ALU_ADD;
      3'b001:  r = ALU_SHL;
      3'b010:  r = ALU_LT_S;
      3'b011:  r = ALU_LT_U;
      3'b100:  r = ALU_XOR;
      3'b101:  r = alt_bit ? ALU_SHR_A : ALU_SHR_L;
      3'b110:  r = ALU_OR;
      default: r = ALU_AND;
    endcase
    return r;
  endfunction

  always_comb begin
    op_o   = ALU_PASS_B;
    word_o = 1'b0;
    opa_o  = rs1_val_i;
    opb_o  = '0;
    case (opcode)
      OPC_REG: begin
        op_o  = map_fn3(fn3, 1'b1, alt);
        opb_o = rs2_val_i;
      end
      OPC_IMM: begin
        op_o  = map_fn3(fn3, 1'b0, alt);
        opb_o = imm_short;
      end
      OPC_REG_W, OPC_IMM_W: begin
        if (fn3 == 3'b000 || fn3 == 3'b001 || fn3 == 3'b101) begin
          op_o   = map_fn3(fn3, opcode == OPC_REG_W, alt);
          word_o = 1'b1;
          opb_o  = (opcode == OPC_REG_W) ? rs2_val_i : imm_short;
        end
      end
      OPC_UPPER: begin
        opb_o = imm_upper;
      end
      OPC_PCREL: begin
        op_o  = ALU_ADD;
        opa_o = pc_i;
        opb_o = imm_upper;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rv64_alu_shift.sv
module rv64_alu_shift
  import rv64_alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            word_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] prep;
  logic [SHW-1:0]  amt;
  logic            fill;
  logic [XLEN-1:0] stage [SHW+1];

  always_comb begin
    if (word_i) begin
      src = arith_i ? {{(XLEN-WORD_W){val_i[WORD_W-1]}}, val_i[WORD_W-1:0]}
                    : {{(XLEN-WORD_W){1'b0}}, val_i[WORD_W-1:0]};
      amt = {1'b0, amt_i[SHW-2:0]};
    end else begin
      src = val_i;
      amt = amt_i;
    end
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      prep[i] = left_i ? src[XLEN-1-i] : src[i];
    end
  end

  assign fill     = arith_i & ~left_i & prep[XLEN-1];
  assign stage[0] = prep;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][XLEN-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      res_o[i] = left_i ? stage[SHW][XLEN-1-i] : stage[SHW][i];
    end
  end

endmodule

// File: rtl/rv64_alu_exec.sv
module rv64_alu_exec
  import rv64_alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o
);

  logic            is_sub;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] raw;

  assign is_sub = (op_i == ALU_SUB);
  assign sum    = opa_i + (is_sub ? ~opb_i : opb_i) + {{(XLEN-1){1'b0}}, is_sub};

  rv64_alu_shift #(.XLEN(XLEN)) i_shift (
    .val_i   (opa_i),
    .amt_i   (opb_i[SHW-1:0]),
    .word_i  (word_i),
    .left_i  (op_i == ALU_SHL),
    .arith_i (op_i == ALU_SHR_A),
    .res_o   (shifted)
  );

  always_comb begin
    case (op_i)
      ALU_ADD, ALU_SUB:            raw = sum;
      ALU_SHL, ALU_SHR_L, ALU_SHR_A: raw = shifted;
      ALU_LT_S: raw = {{(XLEN-1){1'b0}}, $signed(opa_i) < $signed(opb_i)};
      ALU_LT_U: raw = {{(XLEN-1){1'b0}}, opa_i < opb_i};
      ALU_XOR:  raw = opa_i ^ opb_i;
      ALU_OR:   raw = opa_i | opb_i;
      ALU_AND:  raw = opa_i & opb_i;
      default:  raw = opb_i;
    endcase
  end

  assign res_o = word_i ? {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]} : raw;

endmodule

// File: rtl/rv64_int_alu.sv
module rv64_int_alu
  import rv64_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic [XLEN-1:0] rd_val_o
);

  alu_op_e         op;
  logic            word;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;

  rv64_alu_decode #(.XLEN(XLEN)) i_decode (
    .insn_i    (insn_i),
    .pc_i      (pc_i),
    .rs1_val_i (rs1_val_i),
    .rs2_val_i (rs2_val_i),
    .op_o      (op),
    .word_o    (word),
    .opa_o     (opa),
    .opb_o     (opb)
  );

  rv64_alu_exec #(.XLEN(XLEN)) i_exec (
    .op_i   (op),
    .word_i (word),
    .opa_i  (opa),
    .opb_i  (opb),
    .res_o  (rd_val_o)
  );

endmodule

// File: rtl/rv64_int_alu_chk.sv
module rv64_int_alu_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] rs2_val_i,
  input logic [XLEN-1:0] rd_val_o
);

  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [XLEN-1:0] upper;
  logic            known;

  assign opc   = insn_i[6:0];
  assign f3    = insn_i[14:12];
  assign upper = {{(XLEN-32){insn_i[31]}}, insn_i[31:12], 12'b0};
  assign known = (opc == 7'h33) || (opc == 7'h13) || (opc == 7'h3B) ||
                 (opc == 7'h1B) || (opc == 7'h37) || (opc == 7'h17);

  always_comb begin
    if (!known) begin
      assert_unknown_zero_R11: assert (rd_val_o == '0)
        else $error("unknown opcode produced a nonzero result");
    end
    if ((opc == 7'h3B) || (opc == 7'h1B)) begin
      assert_word_sext_R7: assert (rd_val_o[XLEN-1:31] == '0 || rd_val_o[XLEN-1:31] == '1)
        else $error("word result not sign-extended from bit 31");
    end
    if (((opc == 7'h33) || (opc == 7'h13)) && (f3 == 3'b010 || f3 == 3'b011)) begin
      assert_cmp_bool_R6: assert (rd_val_o[XLEN-1:1] == '0)
        else $error("compare result is not 0 or 1");
    end
    if (opc == 7'h37) begin
      assert_upper_imm_R9: assert (rd_val_o == upper)
        else $error("upper-immediate result mismatch");
    end
    if (opc == 7'h17) begin
      assert_pc_rel_R10: assert (rd_val_o == pc_i + upper)
        else $error("pc-relative result mismatch");
    end
    if ((opc == 7'h33) && (f3 == 3'b000) && !insn_i[30]) begin
      assert_add_wrap_R1: assert (rd_val_o == rs1_val_i + rs2_val_i)
        else $error("register add mismatch");
    end
  end

endmodule

bind rv64_int_alu rv64_int_alu_chk #(.XLEN(XLEN)) i_chk (
  .insn_i    (insn_i),
  .pc_i      (pc_i),
  .rs1_val_i (rs1_val_i),
  .rs2_val_i (rs2_val_i),
  .rd_val_o  (rd_val_o)
);

// File: tb/test_rv64_int_alu.sv
module test_rv64_int_alu;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;
  localparam int WD_LIMIT   = 2000;

  localparam logic [6:0] T_REG   = 7'h33;
  localparam logic [6:0] T_IMM   = 7'h13;
  localparam logic [6:0] T_REGW  = 7'h3B;
  localparam logic [6:0] T_IMMW  = 7'h1B;
  localparam logic [6:0] T_LUI   = 7'h37;
  localparam logic [6:0] T_AUIPC = 7'h17;
  localparam logic [6:0] T_BR    = 7'h63;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_0BAD_F00D;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                        input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3,
                                        input logic [6:0] opc);
    return {imm, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [6:0] opc);
    return {imm, 5'd1, opc};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] pc;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;

  localparam vec_t TBL [NV] = '{
    // R1 add / sub with wrap
    '{enc_r(7'h00, 3'd0, T_REG), 64'h0, 64'd5, 64'd7, 64'd12, 8'd1},
    '{enc_r(7'h00, 3'd0, T_REG), 64'h0, ONES, 64'd2, 64'd1, 8'd1},
    '{enc_r(7'h20, 3'd0, T_REG), 64'h0, 64'd0, 64'd1, ONES, 8'd1},
    '{enc_r(7'h20, 3'd0, T_REG), 64'h0, 64'd100, 64'd58, 64'd42, 8'd1},
    // R2 addi, rs2 ignored
    '{enc_i(12'hFFD, 3'd0, T_IMM), 64'h0, 64'd10, JUNK, 64'd7, 8'd2},
    // R5 bit 30 in an immediate add is just immediate bit 10
    '{enc_i(12'h400, 3'd0, T_IMM), 64'h0, 64'd0, JUNK, 64'h400, 8'd5},
    // R3 logic ops
    '{enc_i(12'hFFF, 3'd4, T_IMM), 64'h0, 64'hFF, JUNK, 64'hFFFF_FFFF_FFFF_FF00, 8'd3},
    '{enc_i(12'h800, 3'd6, T_IMM), 64'h0, 64'h10, JUNK, 64'hFFFF_FFFF_FFFF_F810, 8'd3},
    '{enc_i(12'h0FF, 3'd7, T_IMM), 64'h0, 64'h1234_5678_9ABC_DEF0, JUNK, 64'hF0, 8'd3},
    '{enc_r(7'h00, 3'd7, T_REG), 64'h0, 64'hF0F0, 64'hFF00, 64'hF000, 8'd3},
    '{enc_r(7'h00, 3'd6, T_REG), 64'h0, 64'hF0F0, 64'hFF00, 64'hFFF0, 8'd3},
    '{enc_r(7'h00, 3'd4, T_REG), 64'h0, 64'hF0F0, 64'hFF00, 64'h0FF0, 8'd3},
    // R4 64-bit shifts, 6-bit amounts
    '{enc_r(7'h00, 3'd1, T_REG), 64'h0, 64'd1, 64'h43, 64'd8, 8'd4},
    '{enc_r(7'h00, 3'd5, T_REG), 64'h0, MSB, 64'd63, 64'd1, 8'd4},
    '{enc_r(7'h20, 3'd5, T_REG), 64'h0, MSB, 64'hFC, 64'hFFFF_FFFF_FFFF_FFF8, 8'd5},
    '{enc_i(12'h03F, 3'd1, T_IMM), 64'h0, 64'd1, JUNK, MSB, 8'd4},
    '{enc_i(12'h404, 3'd5, T_IMM), 64'h0, MSB, JUNK, 64'hF800_0000_0000_0000, 8'd5},
    '{enc_i(12'h020, 3'd5, T_IMM), 64'h0, 64'hFFFF_FFFF_0000_0000, JUNK, 64'hFFFF_FFFF, 8'd4},
    '{enc_i(12'h420, 3'd5, T_IMM), 64'h0, MSB, JUNK, 64'hFFFF_FFFF_8000_0000, 8'd4},
    // R6 compares
    '{enc_r(7'h00, 3'd2, T_REG), 64'h0, ONES, 64'd1, 64'd1, 8'd6},
    '{enc_r(7'h00, 3'd3, T_REG), 64'h0, ONES, 64'd1, 64'd0, 8'd6},
    '{enc_r(7'h00, 3'd2, T_REG), 64'h0, 64'd5, 64'd5, 64'd0, 8'd6},
    '{enc_i(12'hFFC, 3'd2, T_IMM), 64'h0, 64'hFFFF_FFFF_FFFF_FFFB, JUNK, 64'd1, 8'd6},
    '{enc_i(12'hFFF, 3'd3, T_IMM), 64'h0, 64'd1, JUNK, 64'd1, 8'd6},
    '{enc_r(7'h00, 3'd3, T_REG), 64'h0, 64'd1, ONES, 64'd1, 8'd6},
    // R7 word add / sub
    '{enc_r(7'h00, 3'd0, T_REGW), 64'h0, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 8'd7},
    '{enc_r(7'h20, 3'd0, T_REGW), 64'h0, 64'd0, 64'd1, ONES, 8'd7},
    '{enc_i(12'hFFA, 3'd0, T_IMMW), 64'h0, 64'hFFFF_FFFF_0000_0005, JUNK, ONES, 8'd7},
    '{enc_i(12'h001, 3'd0, T_IMMW), 64'h0, 64'h1234_5678_0000_0001, JUNK, 64'd2, 8'd7},
    // R8 word shifts
    '{enc_r(7'h00, 3'd1, T_REGW), 64'h0, 64'd1, 64'h3F, 64'hFFFF_FFFF_8000_0000, 8'd8},
    '{enc_r(7'h00, 3'd5, T_REGW), 64'h0, 64'hFFFF_FFFF_8000_0000, 64'h24, 64'h0800_0000, 8'd8},
    '{enc_r(7'h00, 3'd5, T_REGW), 64'h0, 64'h8000_0000, 64'h20, 64'hFFFF_FFFF_8000_0000, 8'd8},
    '{enc_r(7'h20, 3'd5, T_REGW), 64'h0, 64'h8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, 8'd8},
    '{enc_r(7'h20, 3'd5, T_REGW), 64'h0, 64'hFFFF_FFFF_7000_0000, 64'd4, 64'h0700_0000, 8'd8},
    '{enc_i(12'h001, 3'd1, T_IMMW), 64'h0, 64'h4000_0000, JUNK, 64'hFFFF_FFFF_8000_0000, 8'd8},
    '{enc_i(12'h004, 3'd5, T_IMMW), 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, JUNK, 64'h0FFF_FFFF, 8'd8},
    '{enc_i(12'h404, 3'd5, T_IMMW), 64'h0, 64'h8000_0000, JUNK, 64'hFFFF_FFFF_F800_0000, 8'd8},
    // R9 upper immediate
    '{enc_u(20'h80000, T_LUI), 64'h0, JUNK, JUNK, 64'hFFFF_FFFF_8000_0000, 8'd9},
    '{enc_u(20'h12345, T_LUI), 64'h0, JUNK, JUNK, 64'h1234_5000, 8'd9},
    // R10 pc-relative upper immediate
    '{enc_u(20'hFFFFF, T_AUIPC), 64'h1000, JUNK, JUNK, 64'd0, 8'd10},
    '{enc_u(20'h00001, T_AUIPC), 64'h100, JUNK, JUNK, 64'h1100, 8'd10},
    '{enc_u(20'h80000, T_AUIPC), 64'h0, JUNK, JUNK, 64'hFFFF_FFFF_8000_0000, 8'd10},
    // R11 unrecognized encodings
    '{{25'h1FF_FFFF, T_BR}, 64'h40, JUNK, JUNK, 64'd0, 8'd11},
    '{enc_r(7'h00, 3'd2, T_REGW), 64'h0, 64'd3, 64'd9, 64'd0, 8'd11}
  };

  logic [31:0]     insn;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rs1v;
  logic [XLEN-1:0] rs2v;
  logic [XLEN-1:0] rdv;
  logic            clk;
  int              total;
  int              bad;
  int              cycles;

  rv64_int_alu #(.XLEN(XLEN)) i_rv64_int_alu (
    .insn_i    (insn),
    .pc_i      (pc),
    .rs1_val_i (rs1v),
    .rs2_val_i (rs2v),
    .rd_val_o  (rdv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] exp);
    total++;
    if (rdv !== exp) begin
      bad++;
      $display("FAIL %s: insn=%h got=%h expected=%h", tag, insn, rdv, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    insn = i;
    pc   = p;
    rs1v = a;
    rs2v = b;
    @(posedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        bad++;
        total++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0;
    bad   = 0;
    insn  = '0;
    pc    = '0;
    rs1v  = '0;
    rs2v  = '0;

    // Idle state: all-zero inputs decode as no known operation (R11)
    @(posedge clk);
    check("R11 idle zero", 64'd0);

    for (int n = 0; n < NV; n++) begin
      apply(TBL[n].insn, TBL[n].pc, TBL[n].a, TBL[n].b);
      check($sformatf("R%0d vector %0d", TBL[n].req, n), TBL[n].exp);
    end

    // R12: changing register index fields leaves the sum unchanged
    apply({7'h00, 5'd31, 5'd31, 3'd0, 5'd31, T_REG}, 64'h0, 64'd1000, 64'd24);
    check("R12 index fields all ones", 64'd1024);
    apply({7'h00, 5'd0, 5'd0, 3'd0, 5'd0, T_REG}, 64'h0, 64'd1000, 64'd24);
    check("R12 index fields zero", 64'd1024);

    // R2: immediate form ignores rs2 (two different rs2 values)
    apply(enc_i(12'h005, 3'd0, T_IMM), 64'h0, 64'd1, 64'd0);
    check("R2 imm rs2=0", 64'd6);
    apply(enc_i(12'h005, 3'd0, T_IMM), 64'h0, 64'd1, ONES);
    check("R2 imm rs2=ones", 64'd6);

    // R10: pc wraps modulo 2^64
    apply(enc_u(20'h00001, T_AUIPC), ONES, 64'd0, 64'd0);
    check("R10 pc wrap", 64'h0FFF);

    // R4: shift amount 64 behaves as 0, amount 0 passes value
    apply(enc_r(7'h00, 3'd1, T_REG), 64'h0, 64'h1234, 64'd64);
    check("R4 amount 64 is 0", 64'h1234);

    // R11: word opcode with funct3 100 is unrecognized
    apply(enc_r(7'h00, 3'd4, T_REGW), 64'h0, 64'hFF, 64'h0F);
    check("R11 word xor slot", 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule